// File: doc/BRIEF.md
# Local I/O Interrupt Aggregator

This block gathers level-sensitive interrupt requests from ten on-board peripheral sources and folds them into a single interrupt line toward the CPU. Every request passes through a two-stage synchroniser and is then recorded in a 16-bit status register. In that register a source that is asking for service reads as 0 and an idle source reads as 1. An 8-bit mask register picks which of the low eight sources may raise the CPU line. The line is registered and is asserted whenever at least one unmasked source is pending.

The sources sit at fixed bit positions. Position 0 is serial controller A and position 1 is serial controller B. Position 2 is vertical retrace and position 3 is the parallel port. Positions 4 through 7 are SCSI, Ethernet, the geometry engine and the FIFO-full flag, in that order. Position 8 is the bus AC-fail warning, and position 9 is a vertical-retrace status copy that is only for reading. Because the mask is eight bits wide, positions 8 and 9 can be seen in the status register but can never raise the interrupt. The SCSI request arrives on its input pin with inverted polarity, and the block corrects for this.

Software reaches both registers through a simple word port. Reads are combinational on the address. Writes take effect on the clock edge where the write strobe is high.

Top module: `lio_irq_agg`

## Requirements
- R1: While reset is held and on the first clock after it, the status read returns 0x000003FF, the mask read returns 0 and `cpu_irq` is low.
- R2: Status bit n (n = 0..9) reads 0 while source n requests service and reads 1 while it is idle. Status bits 15..10 and read bits 31..16 are 0.
- R3: Source 4 (SCSI) is active-low at its pin: `src_raw[4]` = 0 means a request. All other `src_raw` bits are active-high.
- R4: `cpu_irq` is high exactly when (~status[7:0] & mask) is nonzero. It takes that value on the clock edge after the status or mask change.
- R5: Sources 8 and 9 never assert `cpu_irq`, even when the mask holds 0xFF.
- R6: A write to byte address 0x8 loads `reg_wdata[7:0]` into the mask on that edge. A read of 0x8 returns the mask in bits 7..0 with zeros above it.
- R7: The status register at byte address 0x0 is read-only, so a write there changes neither the status nor the mask.
- R8: A change on a source pin reaches the status register on the third rising edge after it is applied. The first two edges load the synchroniser stages.
- R9: A read from any byte address other than 0x0 and 0x8 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_raw | input | 10 | Raw source request pins; bit 4 active-low, the others active-high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address (0x0 status, 0x8 mask) |
| reg_wdata | input | 8 | Write data for the mask |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| cpu_irq | output | 1 | Registered interrupt line to the CPU, active high |

## Verification
A wrong internal state shows up at the ports in one of three ways. If a synchroniser stage or a status bit is stuck, the status read shows it on the third edge after a pin moves. If a mask bit is corrupt, the mask read shows it one edge after the write. If the combining logic is wrong, `cpu_irq` is wrong one edge after the status or mask settles. The bench therefore samples the status word and the interrupt line in the edge before and the edge after each expected change. This catches both late and early updates, as well as a wrong SCSI polarity, a wrong source position, mask bits that leak to sources 8 or 9, and writes to the status address that have an effect.

// File: rtl/lio_irq_pkg.sv
`timescale 1ns/1ps
package lio_irq_pkg;

    localparam int unsigned SRC_N      = 10;
    localparam int unsigned MASK_W     = 8;
    localparam int unsigned STAT_W     = 16;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned ADDR_W     = 4;
    localparam int unsigned SYNC_DEPTH = 2;

    // fixed source positions
    typedef enum int unsigned {
        SRC_SER_A   = 0,
        SRC_SER_B   = 1,
        SRC_VRETR   = 2,
        SRC_PARPORT = 3,
        SRC_SCSI    = 4,
        SRC_ENET    = 5,
        SRC_GEOM    = 6,
        SRC_FIFOFUL = 7,
        SRC_ACFAIL  = 8,
        SRC_VR_STAT = 9
    } lio_src_e;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STATUS = 4'h0,
        ADDR_MASK   = 4'h8
    } lio_addr_e;

    // pins whose request level is low
    localparam logic [SRC_N-1:0] ACTIVE_LOW_SRC = SRC_N'(1) << SRC_SCSI;

    // pin levels that mean "idle", used as synchroniser reset value
    localparam logic [SRC_N-1:0] IDLE_PIN_LEVEL = ACTIVE_LOW_SRC;

    // convert pin levels to active-high request flags
    function automatic logic [SRC_N-1:0] pins_to_req(input logic [SRC_N-1:0] pins);
        return pins ^ ACTIVE_LOW_SRC;
    endfunction

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] wdata;
    } lio_bus_t;

endpackage

// File: rtl/lio_sync.sv
`timescale 1ns/1ps
module lio_sync #(
    parameter int unsigned   W       = lio_irq_pkg::SRC_N,
    parameter int unsigned   DEPTH   = lio_irq_pkg::SYNC_DEPTH,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/lio_status.sv
`timescale 1ns/1ps
module lio_status
    import lio_irq_pkg::*;
#(
    parameter int unsigned N  = SRC_N,
    parameter int unsigned SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  sync_pins,
    output logic [SW-1:0] status
);

    localparam int unsigned PAD_W = SW - N;

    logic [SW-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) status_q <= {{PAD_W{1'b0}}, {N{1'b1}}};
        else     status_q <= {{PAD_W{1'b0}}, ~pins_to_req(sync_pins)};
    end

    assign status = status_q;

    AST_STATUS_RESET: assert property (@(posedge clk)
        rst |=> status_q == {{PAD_W{1'b0}}, {N{1'b1}}}); // R1

    AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status_q[SW-1:N] == '0); // R2

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        $stable(sync_pins) |=> $stable(status_q)); // R7

endmodule

// File: rtl/lio_mask.sv
`timescale 1ns/1ps
module lio_mask #(
    parameter int unsigned MW = lio_irq_pkg::MASK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [MW-1:0] wdata,
    output logic [MW-1:0] mask
);

    logic [MW-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (wr_en) mask_q <= wdata;
    end

    assign mask = mask_q;

    AST_MASK_RESET: assert property (@(posedge clk)
        rst |=> mask_q == '0); // R1

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_q)); // R6

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mask_q == $past(wdata)); // R6

endmodule

// File: rtl/lio_irq_agg.sv
`timescale 1ns/1ps
module lio_irq_agg
    import lio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_raw,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [MASK_W-1:0] reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              cpu_irq
);

    lio_bus_t          bus;
    logic [SRC_N-1:0]  sync_pins;
    logic [STAT_W-1:0] status;
    logic [MASK_W-1:0] mask;
    logic              mask_wr;
    logic [MASK_W-1:0] pending;
    logic              irq_q;

    assign bus     = '{wr: reg_wr, addr: reg_addr, wdata: reg_wdata};
    assign mask_wr = bus.wr && (bus.addr == ADDR_MASK);

    lio_sync #(
        .W       (SRC_N),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (IDLE_PIN_LEVEL)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_raw),
        .q   (sync_pins)
    );

    lio_status #(
        .N  (SRC_N),
        .SW (STAT_W)
    ) u_status (
        .clk       (clk),
        .rst       (rst),
        .sync_pins (sync_pins),
        .status    (status)
    );

    lio_mask #(
        .MW (MASK_W)
    ) u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr_en (mask_wr),
        .wdata (bus.wdata),
        .mask  (mask)
    );

    // only the low MASK_W sources can be enabled
    assign pending = ~status[MASK_W-1:0] & mask;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pending;
    end

    assign cpu_irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        case (bus.addr)
            ADDR_STATUS: reg_rdata = BUS_W'(status);
            ADDR_MASK:   reg_rdata = BUS_W'(mask);
            default:     reg_rdata = '0;
        endcase
    end

    AST_IRQ_RESET: assert property (@(posedge clk)
        rst |=> !cpu_irq); // R1

    AST_IRQ_MASK_OFF: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |=> !cpu_irq); // R4

    AST_IRQ_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        (&status[MASK_W-1:0]) |=> !cpu_irq); // R5

endmodule

// File: tb/tb_lio_irq_agg.sv
`timescale 1ns/100ps
module tb_lio_irq_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  src_raw = 10'h010;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [31:0] reg_rdata;
    logic        cpu_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // logical request flags kept by the bench (1 = requesting)
    logic [9:0] req = '0;

    typedef struct {
        logic [31:0] exp_data;
        logic        exp_irq;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  push_ev;

    always #4 clk = ~clk;

    lio_irq_agg dut (
        .clk       (clk),
        .rst       (rst),
        .src_raw   (src_raw),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_irq   (cpu_irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(push_ev);
            #0.2;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (reg_rdata !== it.exp_data || cpu_irq !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, reg_rdata, cpu_irq, it.exp_data, it.exp_irq);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] d,
                             input logic irq, input string tag);
        item_t it;
        reg_addr = a;
        it.exp_data = d;
        it.exp_irq  = irq;
        it.tag      = tag;
        sb_q.push_back(it);
        -> push_ev;
        #0.5;
    endtask

    task automatic set_req(input logic [9:0] r);
        req     = r;
        src_raw = r ^ 10'h010; // R3: SCSI pin is active-low
    endtask

    function automatic logic [31:0] exp_status();
        return {22'h0, ~req};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    initial begin
        step(1);
        expect_rd(4'h0, 32'h3FF, 1'b0, "R1 status in reset");
        step(3);
        rst = 1'b0;
        step(1);
        expect_rd(4'h0, 32'h3FF, 1'b0, "R1 status after reset");
        expect_rd(4'h8, 32'h0,   1'b0, "R1 mask after reset");

        // source 0 request, mask 0
        set_req(10'h001);
        step(2);
        expect_rd(4'h0, 32'h3FF, 1'b0, "R8 status not yet updated after two edges");
        step(1);
        expect_rd(4'h0, 32'h3FE, 1'b0, "R8 R2 source 0 visible on third edge");

        // unmask source 0
        wr(4'h8, 8'h01);
        expect_rd(4'h8, 32'h01, 1'b0, "R6 mask loaded, irq one edge behind");
        step(1);
        expect_rd(4'h8, 32'h01, 1'b1, "R4 irq after mask write");

        // drop source 0
        set_req(10'h000);
        step(3);
        expect_rd(4'h0, 32'h3FF, 1'b1, "R4 status idle, irq still registered");
        step(1);
        expect_rd(4'h0, 32'h3FF, 1'b0, "R4 irq cleared one edge after status");

        // SCSI active-low pin
        set_req(10'h010);
        step(3);
        expect_rd(4'h0, 32'h3EF, 1'b0, "R3 SCSI low pin reads as request");
        wr(4'h8, 8'h10);
        step(1);
        expect_rd(4'h0, 32'h3EF, 1'b1, "R3 R4 SCSI unmasked raises irq");
        set_req(10'h000);
        step(4);
        expect_rd(4'h0, 32'h3FF, 1'b0, "R3 SCSI high pin reads idle");

        // sources 8 and 9 with full mask
        wr(4'h8, 8'hFF);
        expect_rd(4'h8, 32'hFF, 1'b0, "R6 full mask readback");
        set_req(10'h300);
        step(5);
        expect_rd(4'h0, exp_status(), 1'b0, "R5 sources 8 and 9 never interrupt");

        // write to status address is ignored
        wr(4'h0, 8'h00);
        expect_rd(4'h0, exp_status(), 1'b0, "R7 status unchanged by write");
        expect_rd(4'h8, 32'hFF, 1'b0, "R7 mask unchanged by status write");

        // unmapped address
        expect_rd(4'h4, 32'h0, 1'b0, "R9 unmapped address reads zero");
        expect_rd(4'hC, 32'h0, 1'b0, "R9 unmapped address 0xC reads zero");

        // multi-source pattern: 2, 5, 7, plus 9
        set_req(10'h2A4);
        step(4);
        expect_rd(4'h0, exp_status(), 1'b1, "R2 R4 sources 2 5 7 pending");
        wr(4'h8, 8'h40);
        step(1);
        expect_rd(4'h0, exp_status(), 1'b0, "R4 only geometry engine enabled, none pending");
        set_req(10'h2E4);
        step(4);
        expect_rd(4'h0, exp_status(), 1'b1, "R2 R4 geometry engine request raises irq");
        wr(4'h8, 8'h02);
        step(1);
        expect_rd(4'h8, 32'h02, 1'b0, "R4 serial B enabled but idle");
        set_req(10'h002);
        step(4);
        expect_rd(4'h0, exp_status(), 1'b1, "R2 serial B at bit 1 raises irq");

        // reset again mid-run
        rst = 1'b1;
        step(1);
        expect_rd(4'h8, 32'h0, 1'b0, "R1 reset clears mask and irq");
        rst = 1'b0;
        set_req(10'h000);
        step(4);
        expect_rd(4'h0, 32'h3FF, 1'b0, "R1 status idle after second reset");

        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule